// File: doc/BRIEF.md
# Single-Precision to Half-Precision Rounding Converter

This block narrows one IEEE binary32 operand per cycle into an IEEE binary16 result. It rebiases the exponent, keeps the upper ten fraction bits, and derives four rounding inputs from the discarded tail: the kept least-significant bit (L), the first dropped bit (R), the second dropped bit (G) and the OR of every remaining dropped bit (S). A round-up decision for one of five modes is added into the packed exponent-and-fraction field, so a fraction carry moves into the exponent without extra logic. Overflow, gradual underflow, NaN, infinity and zero are handled. Four exception flags are reported with each result.

The rounding mode sits in a small register that is written through a strobe and comes out of reset as nearest-even. Each accepted operand is converted with the mode held in that register before the clock edge that accepts it. Results and flags appear one cycle after the operand and are held until the next accepted operand.

Top module: `fp32_to_fp16_cvt`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Result and flags change only when an operand is accepted and hold their values otherwise. Reset clears `out_valid`, the result and all flags.
- R2: The mode register resets to 0 and loads `mode_in` on an edge where `mode_wr` is high. An operand accepted on the same edge uses the old mode. Codes are: 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward −infinity, 4 nearest with ties away from zero. Codes 5 to 7 behave as code 0.
- R3: For a finite, nonzero input the result field is the exponent minus 127 plus 15, followed by fraction bits 22..13. L is fraction bit 13, R is bit 12, G is bit 11 and S is the OR of bits 10..0. The result is exact when R, G and S are all clear.
- R4: Under nearest-even the magnitude is incremented when {L,R,G,S} = 0101, or {L,R,G} = 011, or {L,R} = 11. For example, 0x3F801000 gives 0x3C00 and 0x3F803000 gives 0x3C02.
- R5: Toward zero never increments. Toward +infinity increments only positive inexact results, and toward −infinity increments only negative inexact results. Inexact means R, G or S is set. So 0x3F801000 gives 0x3C01 toward +infinity, and 0x3F803000 gives 0x3C01 both toward zero and toward −infinity.
- R6: Under ties-away the magnitude is incremented whenever R is set, so an exact half moves away from zero.
- R7: A rebiased exponent of 31 or more, or a rounding carry into exponent 31, yields a signed infinity (x7C00) with both the overflow and inexact flags set, in every mode.
- R8: A result below the normal range is formed by gradual underflow as a subnormal, and is never flushed to zero. The underflow flag is set when the exponent before rounding is below the normal range and the result is inexact. Rounding up may reach the smallest normal, 0x0400.
- R9: A NaN input gives the sign bit followed by 0x7E00. The invalid flag is set only when input fraction bit 22 is clear (a signalling NaN). Infinity gives the sign bit followed by 0x7C00, and zero gives a signed zero. Neither raises any flag.
- R10: The result sign bit always equals the input sign bit.
- R11: A fraction carry during rounding increments the exponent. For example, 0x3FFFF000 under nearest-even gives 0x4000 with the inexact flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Load strobe for the rounding-mode register |
| mode_in | input | 3 | New rounding-mode code |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 32 | binary32 operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 16 | binary16 result |
| flag_inexact | output | 1 | Result differs from the exact value |
| flag_overflow | output | 1 | Result exceeded the binary16 range |
| flag_underflow | output | 1 | Tiny and inexact result |
| flag_invalid | output | 1 | Signalling NaN operand |

## Verification
Several properties are checked on every cycle. These are the valid timing and hold behaviour, sign preservation, the quiet NaN pattern and its invalid flag, infinity on every overflow, the link between the underflow and inexact flags, and that toward-zero never overflows an in-range operand. Only the bench's scenarios can show the exact increment decisions for each mode against the tie vectors. The same holds for the mode-register timing around a write on the same edge, subnormal rounding up to the smallest normal, and the carry into the exponent. A reference model compares every cycle over directed vectors and a randomized sweep.

// File: rtl/f2h_pkg.sv
package f2h_pkg;
  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_TO_ZERO   = 3'd1,
    RM_UP        = 3'd2,
    RM_DOWN      = 3'd3,
    RM_NEAR_AWAY = 3'd4
  } rmode_e;

  typedef struct packed {
    logic nx;
    logic of;
    logic uf;
    logic nv;
  } fflags_t;
endpackage

// File: rtl/f2h_align.sv
// Rebias and right-align the significand; extract L/R/G/S for rounding.
module f2h_align #(
  parameter int SE = 8,
  parameter int SM = 23,
  parameter int DE = 5,
  parameter int DM = 10
) (
  input  logic [SE-1:0]    exp_i,
  input  logic [SM-1:0]    man_i,
  output logic [DE+DM-1:0] pre_o,
  output logic             lsb_o,
  output logic             r_o,
  output logic             g_o,
  output logic             s_o,
  output logic             tiny_o,
  output logic             huge_o
);
  localparam int SBIAS = (1 << (SE-1)) - 1;
  localparam int DBIAS = (1 << (DE-1)) - 1;
  localparam int SIGW  = SM + 1;
  localparam int DROP  = SM - DM;
  localparam int PAD   = SIGW + 2;
  localparam int EW    = SE + 2;
  localparam int EMAXD = (1 << DE) - 1;
  localparam logic signed [EW-1:0] OFFS  = EW'(DBIAS - SBIAS);
  localparam logic signed [EW-1:0] ONE   = EW'(1);
  localparam logic signed [EW-1:0] DROPS = EW'(DROP);
  localparam logic signed [EW-1:0] PADS  = EW'(PAD);
  localparam logic signed [EW-1:0] TOPS  = EW'(EMAXD);

  logic [SIGW-1:0]        sig;
  logic [SE-1:0]          exp_eff;
  logic signed [EW-1:0]   ee;
  logic signed [EW-1:0]   sh;
  logic [DM+PAD-1:0]      win;

  always_comb begin
    sig     = {|exp_i, man_i};
    exp_eff = (|exp_i) ? exp_i : SE'(1);
    ee      = $signed({2'b00, exp_eff}) + OFFS;
    // normal results drop a fixed tail; subnormals shift further right
    if (ee >= ONE) sh = DROPS;
    else           sh = DROPS + ONE - ee;
    if (sh > PADS) sh = PADS;
    win    = (DM+PAD)'({sig, {PAD{1'b0}}} >> sh);
    r_o    = win[PAD-1];
    g_o    = win[PAD-2];
    s_o    = |win[PAD-3:0];
    lsb_o  = win[PAD];
    tiny_o = (ee < ONE);
    huge_o = (ee >= TOPS);
    pre_o  = {(tiny_o ? {DE{1'b0}} : ee[DE-1:0]), win[DM+PAD-1:PAD]};
  end
endmodule

// File: rtl/f2h_round_dec.sv
// Round-up decision for the five rounding modes.
module f2h_round_dec
  import f2h_pkg::*;
(
  input  rmode_e mode_i,
  input  logic   neg_i,
  input  logic   lsb_i,
  input  logic   r_i,
  input  logic   g_i,
  input  logic   s_i,
  output logic   up_o
);
  logic tail;

  always_comb begin
    tail = r_i | g_i | s_i;
    case (mode_i)
      RM_TO_ZERO:   up_o = 1'b0;
      RM_UP:        up_o = ~neg_i & tail;
      RM_DOWN:      up_o = neg_i & tail;
      RM_NEAR_AWAY: up_o = r_i;
      default:      up_o = ({lsb_i, r_i, g_i, s_i} == 4'b0101) |
                           ({lsb_i, r_i, g_i} == 3'b011) |
                           ({lsb_i, r_i} == 2'b11);
    endcase
  end
endmodule

// File: rtl/f2h_core.sv
// Combinational narrowing datapath: specials, rounding add, flags.
module f2h_core
  import f2h_pkg::*;
#(
  parameter int SE = 8,
  parameter int SM = 23,
  parameter int DE = 5,
  parameter int DM = 10
) (
  input  logic [SE+SM:0]   a_i,
  input  rmode_e           mode_i,
  output logic [DE+DM:0]   res_o,
  output fflags_t          flg_o
);
  localparam int FW = DE + DM;

  logic          sgn;
  logic [SE-1:0] ex;
  logic [SM-1:0] mn;
  logic [FW-1:0] pre;
  logic [FW-1:0] sum;
  logic          lsb, rb, gb, sb, tiny, huge, up, ovf, inx;

  assign sgn = a_i[SE+SM];
  assign ex  = a_i[SE+SM-1:SM];
  assign mn  = a_i[SM-1:0];

  f2h_align #(.SE(SE), .SM(SM), .DE(DE), .DM(DM)) u_align (
    .exp_i (ex),
    .man_i (mn),
    .pre_o (pre),
    .lsb_o (lsb),
    .r_o   (rb),
    .g_o   (gb),
    .s_o   (sb),
    .tiny_o(tiny),
    .huge_o(huge)
  );

  f2h_round_dec u_rdec (
    .mode_i(mode_i),
    .neg_i (sgn),
    .lsb_i (lsb),
    .r_i   (rb),
    .g_i   (gb),
    .s_i   (sb),
    .up_o  (up)
  );

  always_comb begin
    sum   = pre + FW'(up);
    inx   = rb | gb | sb;
    ovf   = huge | (&sum[FW-1:DM]);
    res_o = {sgn, sum};
    flg_o = '{nx: inx | ovf, of: ovf, uf: tiny & inx, nv: 1'b0};
    if (ovf) res_o = {sgn, {DE{1'b1}}, {DM{1'b0}}};
    if (&ex) begin
      flg_o = '0;
      if (|mn) begin
        res_o    = {sgn, {DE{1'b1}}, 1'b1, {(DM-1){1'b0}}};
        flg_o.nv = ~mn[SM-1];
      end else begin
        res_o = {sgn, {DE{1'b1}}, {DM{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/fp32_to_fp16_cvt.sv
// Registered binary32 -> binary16 converter with a rounding-mode register.
module fp32_to_fp16_cvt
  import f2h_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_wr,
  input  logic [2:0]  mode_in,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        out_valid,
  output logic [15:0] out_data,
  output logic        flag_inexact,
  output logic        flag_overflow,
  output logic        flag_underflow,
  output logic        flag_invalid
);
  logic [2:0]  mode_q, mode_d;
  logic        vld_q;
  logic [15:0] res_q, res_d, core_res;
  fflags_t     flg_q, flg_d, core_flg;

  f2h_core #(.SE(8), .SM(23), .DE(5), .DM(10)) u_core (
    .a_i   (in_data),
    .mode_i(rmode_e'(mode_q)),
    .res_o (core_res),
    .flg_o (core_flg)
  );

  always_comb begin
    mode_d = mode_wr  ? mode_in  : mode_q;
    res_d  = in_valid ? core_res : res_q;
    flg_d  = in_valid ? core_flg : flg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 3'(RM_NEAR_EVEN);
      vld_q  <= 1'b0;
      res_q  <= '0;
      flg_q  <= '0;
    end else begin
      mode_q <= mode_d;
      vld_q  <= in_valid;
      res_q  <= res_d;
      flg_q  <= flg_d;
    end
  end

  assign out_valid      = vld_q;
  assign out_data       = res_q;
  assign flag_inexact   = flg_q.nx;
  assign flag_overflow  = flg_q.of;
  assign flag_underflow = flg_q.uf;
  assign flag_invalid   = flg_q.nv;

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(flg_q)));
  p_sign_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_data[15] == $past(in_data[31])));
  p_nan_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_data[30:23] == 8'hFF) && (|in_data[22:0])) |=>
    ((out_data[14:0] == 15'h7E00) && (flag_invalid == !$past(in_data[22]))));
  p_no_invalid_finite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_invalid) |-> (out_data[14:9] == 6'h3F));
  p_inf_on_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_overflow) |-> ((out_data[14:0] == 15'h7C00) && flag_inexact));
  p_underflow_tiny_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_underflow) |-> (flag_inexact && (out_data[14:10] <= 5'd1)));
  p_rtz_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode_q == 3'(RM_TO_ZERO)) && (in_data[30:23] < 8'd143)) |=>
    (out_data[14:10] != 5'h1F));
endmodule

// File: tb/fp32_to_fp16_cvt_tb.sv
`timescale 1ns/1ps
module fp32_to_fp16_cvt_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_wr;
  logic [2:0]  mode_in;
  logic        in_valid;
  logic [31:0] in_data;
  logic        out_valid;
  logic [15:0] out_data;
  logic        flag_inexact, flag_overflow, flag_underflow, flag_invalid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state
  int          m_mode;
  bit          e_valid;
  logic [15:0] e_res;
  logic [3:0]  e_flg;

  always #2 clk = ~clk;

  fp32_to_fp16_cvt u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
    .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data), .flag_inexact(flag_inexact),
    .flag_overflow(flag_overflow), .flag_underflow(flag_underflow),
    .flag_invalid(flag_invalid)
  );

  // Returns {nx, of, uf, nv, result[15:0]} computed from exact value arithmetic.
  function automatic logic [19:0] ref_cvt(input logic [31:0] a, input int md);
    logic   s;
    int     ef, eu, qe, k, enc;
    longint sig, tr, rem, half;
    bit     inx, inc, uf;
    s  = a[31];
    ef = int'(a[30:23]);
    if (md > 4) md = 0;
    if (ef == 255) begin
      if (a[22:0] != 0) return {3'b000, ~a[22], s, 15'h7E00};
      return {4'b0000, s, 15'h7C00};
    end
    sig = (ef == 0) ? longint'(a[22:0]) : (longint'(a[22:0]) | (64'sd1 << 23));
    eu  = (ef == 0) ? -126 : ef - 127;
    if (sig == 0) return {4'b0000, s, 15'h0000};
    qe = ((eu < -14) ? -14 : eu) - 10;
    k  = qe - (eu - 23);
    if (k > 62) k = 62;
    tr   = sig >> k;
    rem  = sig - (tr << k);
    half = 64'sd1 << (k - 1);
    inx  = (rem != 0);
    case (md)
      1: inc = 0;
      2: inc = inx && !s;
      3: inc = inx && s;
      4: inc = (rem >= half);
      default: inc = (rem > half) || ((rem == half) && tr[0]);
    endcase
    tr  = tr + longint'(inc);
    enc = (eu >= -14) ? (((eu + 14) << 10) + int'(tr)) : int'(tr);
    if (eu > 15 || enc >= 'h7C00) return {4'b1100, s, 15'h7C00};
    uf = (eu < -14) && inx;
    return {inx, 1'b0, uf, 1'b0, s, enc[14:0]};
  endfunction

  task automatic check(input string tag);
    n_chk++;
    if (out_valid !== e_valid || out_data !== e_res ||
        {flag_inexact, flag_overflow, flag_underflow, flag_invalid} !== e_flg) begin
      n_bad++;
      $display("FAIL %s: got v=%b d=%h f=%b, expected v=%b d=%h f=%b", tag,
               out_valid, out_data,
               {flag_inexact, flag_overflow, flag_underflow, flag_invalid},
               e_valid, e_res, e_flg);
    end
  endtask

  // Apply one cycle of stimulus, then compare one cycle later (1-cycle latency).
  task automatic step(input bit v, input logic [31:0] d, input bit mw,
                      input logic [2:0] mi, input string tag);
    logic [19:0] r;
    in_valid = v; in_data = d; mode_wr = mw; mode_in = mi;
    @(posedge clk);
    #1;
    e_valid = v;
    if (v) begin
      r     = ref_cvt(d, m_mode);
      e_res = r[15:0];
      e_flg = r[19:16];
    end
    if (mw) m_mode = int'(mi);
    in_valid = 0; mode_wr = 0;
    check(tag);
  endtask

  task automatic conv(input logic [31:0] d, input string tag);
    step(1, d, 0, 3'd0, tag);
  endtask

  task automatic setm(input logic [2:0] m);
    step(0, 32'h0, 1, m, "R1");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mode_wr = 0; mode_in = 0; in_valid = 0; in_data = 0;
    m_mode = 0; e_valid = 0; e_res = 0; e_flg = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R1");                              // reset state
    // R2: default mode is nearest-even
    conv(32'h3F803000, "R2");                 // 0x3C02
    // R2: a write on the same edge does not affect that operand
    step(1, 32'h3F803000, 1, 3'd1, "R2");     // still nearest-even
    conv(32'h3F803000, "R2");                 // toward zero -> 0x3C01
    step(0, 32'h0, 0, 3'd0, "R1");            // idle: outputs hold
    // R4 nearest-even ties
    setm(3'd0);
    conv(32'h3F801000, "R4");
    conv(32'h3F803000, "R4");
    conv(32'h3F801001, "R4");
    conv(32'hBF803000, "R4");
    // R5 directed modes
    setm(3'd2);
    conv(32'h3F801000, "R5");
    conv(32'hBF801000, "R5");
    conv(32'h3F803000, "R5");
    setm(3'd3);
    conv(32'h3F803000, "R5");
    conv(32'hBF801000, "R5");
    setm(3'd1);
    conv(32'h3F803000, "R5");
    conv(32'h477FF000, "R5");                 // 0x7BFF, no overflow
    // R6 ties away
    setm(3'd4);
    conv(32'h3F801000, "R6");
    conv(32'hBF801000, "R6");
    conv(32'h33000000, "R6");                 // 2^-25 -> 0x0001
    // R7 overflow
    setm(3'd0);
    conv(32'h47800000, "R7");
    conv(32'hC7800000, "R7");
    conv(32'h477FF000, "R7");                 // rounds into infinity
    setm(3'd1);
    conv(32'h7F000000, "R7");
    // R8 gradual underflow
    setm(3'd0);
    conv(32'h33800000, "R8");                 // exact 0x0001
    conv(32'h33000000, "R8");                 // tie to 0, underflow
    conv(32'h387FF000, "R8");                 // rounds to 0x0400
    conv(32'h38000000, "R8");                 // 2^-15 exact subnormal
    conv(32'h00000001, "R8");
    setm(3'd2);
    conv(32'h00000001, "R8");                 // 0x0001
    // R9 specials
    setm(3'd0);
    conv(32'h7FC00001, "R9");
    conv(32'h7F800001, "R9");
    conv(32'hFF800001, "R9");
    conv(32'hFF800000, "R9");
    conv(32'h7F800000, "R9");
    conv(32'h80000000, "R9");
    // R10 sign
    conv(32'hC0490FDB, "R10");
    // R11 carry into exponent
    conv(32'h3FFFF000, "R11");
    conv(32'h3BFFF000, "R11");
    // R3 exact and normal range
    conv(32'h3F800000, "R3");
    conv(32'h40490000, "R3");
    // R2 reserved codes behave as nearest-even
    setm(3'd5);
    conv(32'h3F801000, "R2");
    conv(32'h3F803000, "R2");
    setm(3'd7);
    conv(32'h3F803000, "R2");
    // randomized sweep across modes, gaps and exponents
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      d = $urandom;
      if ((i % 4) != 0) d[30:23] = 8'(90 + ($urandom % 70));
      step(($urandom % 5) != 0, d, ($urandom % 7) == 0, 3'($urandom % 8), "R3");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule